// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sits in front of an engine that carries out one AUX attempt at a time. It takes one request from its client: read or write, a byte length and a delay to use after a defer. It then starts attempts, reads back each attempt's result and reply code, and decides whether the transaction has passed, should be tried again after a wait, or has failed. Each kind of failure has its own retry budget. Native defers also build up an elapsed-time total, and both the count and the time limit must be reached before a defer ends the transaction.

A write that is acknowledged with a nonzero byte count is turned into a status poll: the next attempt is a zero-length request with the write flag cleared. Waits are timed by an internal microsecond timer made from a cycles-per-microsecond prescaler. When the transaction finishes, the block raises `done` for one cycle, with a pass flag and the last reply code seen.

Top module: `aux_retry_ctrl`

## Requirements
- R1: `req_valid` sampled while idle makes `att_start` high in the next cycle. `busy` is high from then until the transaction finishes. `att_write` and `att_len` carry the request.
- R2: No more than MAX_ATTEMPTS (default 7) attempts are made per transaction. If a retry would exceed that count, the transaction fails.
- R3: Attempt result codes are 0 success, 1 invalid reply, 2 timeout, 3 disconnect and 4 engine busy. With success and reply code 0 (ACK), the transaction passes if a read returned exactly `att_len` bytes or a write returned 0 bytes. `done` and `pass` rise in the cycle after `att_done`, and `last_reply` holds the reply code.
- R4: An ACK on a read that returned a different byte count is retried after ACK_WAIT_US (default 300) µs. It fails on the ACK_RETRY_MAX-th (default 7) such event.
- R5: An ACK on a write that returned a nonzero byte count makes the next attempt a status request with `att_write`=0 and `att_len`=0, after ACK_WAIT_US. It fails on the ACK_RETRY_MAX-th such event.
- R6: Reply code 2 (native DEFER) adds 1 to the defer count and POLL_US to the accumulated time. It fails only when the count is at least DEFER_RETRY_MAX and the accumulated time is at least DEFER_TIME_US. Otherwise the block waits `req_defer_us` and adds that delay to the accumulated time.
- R7: Reply code 8 (I2C DEFER) clears the native defer count and retries after `req_defer_us`. It fails on its I2C_DEFER_MAX-th (default 7) occurrence.
- R8: An invalid-reply result is retried after INVALID_WAIT_US (default 400) µs. It fails on its INVALID_MAX-th (default 2) occurrence.
- R9: A timeout with no native DEFER earlier in the transaction is retried with no wait. It fails on its TIMEOUT_MAX-th (default 3) occurrence.
- R10: Every success result clears the timeout count and the invalid-reply count.
- R11: After a native DEFER has been seen in the transaction, a timeout counts as a defer. It fails when the defer count reaches DEFER_RETRY_MAX, and otherwise it retries after `req_defer_us`.
- R12: Reply codes 1 (NACK) and 4 (I2C NACK), any other unlisted reply code, a disconnect and an engine-busy result each fail the transaction at once.
- R13: A wait of W µs puts the next `att_start` exactly W·CLK_PER_US+1 cycles after the cycle in which `att_done` was high. A zero wait gives 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transaction (taken only when idle) |
| req_write | input | 1 | Transaction is a write |
| req_len | input | LEN_W | Requested byte count |
| req_defer_us | input | US_W | Wait after a defer, in µs |
| att_start | output | 1 | One-cycle pulse that starts an attempt |
| att_write | output | 1 | Write flag of the current attempt |
| att_len | output | LEN_W | Length of the current attempt |
| att_done | input | 1 | Attempt finished; result fields valid |
| att_result | input | 3 | Attempt result code |
| att_reply | input | 4 | Reply code of the attempt |
| att_bytes | input | LEN_W | Byte count reported by the attempt |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| pass | output | 1 | Transaction passed (valid with done) |
| last_reply | output | 4 | Reply code of the last attempt |

## Verification
The hardest case to reach is a defer failure that depends on the accumulated time rather than the count. With the default limits, the attempt cap always ends the transaction first. The bench therefore builds the block with a lower defer count limit and a short time limit. Two runs then separate the cases: one with a nonzero per-request delay, which fails on the time condition, and one with a zero delay, which runs into the attempt cap instead. Defers are also mixed with timeouts and I2C defers, to show the counter being reused and cleared. A responder in the bench answers each attempt from a scripted or random list of outcomes. A requirement-level model predicts every wait length, the request rewrite and the final result.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_INVALID = 3'd1,
    RES_TIMEOUT = 3'd2,
    RES_DISCON  = 3'd3,
    RES_BUSY    = 3'd4
  } att_res_e;

  localparam logic [3:0] RPL_ACK      = 4'h0;
  localparam logic [3:0] RPL_NACK     = 4'h1;
  localparam logic [3:0] RPL_DEFER    = 4'h2;
  localparam logic [3:0] RPL_I2C_NACK = 4'h4;
  localparam logic [3:0] RPL_I2C_DEF  = 4'h8;

  typedef enum logic [1:0] {
    ACT_RETRY = 2'd0,
    ACT_PASS  = 2'd1,
    ACT_FAIL  = 2'd2
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DELAY = 3'd3,
    ST_FIN   = 3'd4
  } st_e;

  // retry budget slots
  localparam int BUD_ACK  = 0;
  localparam int BUD_ACKW = 1;
  localparam int BUD_DEF  = 2;
  localparam int BUD_I2C  = 3;
  localparam int BUD_TMO  = 4;
  localparam int BUD_INV  = 5;
  localparam int NUM_BUD  = 6;

endpackage

// File: rtl/aux_retry_cnt.sv
module aux_retry_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (inc && (cnt_q != {W{1'b1}}));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/aux_us_timer.sv
module aux_us_timer #(
  parameter int CLK_PER_US = 100,
  parameter int US_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            expire
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [US_W-1:0]  left_q, left_d;
  logic             run_q, run_d;
  logic             tick;

  always_comb begin
    tick   = run_q && (pre_q == PRE_LAST);
    expire = tick && (left_q == US_W'(1));
    pre_d  = pre_q;
    left_d = left_q;
    run_d  = run_q;
    if (load) begin
      pre_d  = '0;
      left_d = load_us;
      run_d  = (load_us != '0);
    end else if (run_q) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick) left_d = left_q - 1'b1;
      if (expire) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
    end else if (load || run_q) begin
      pre_q  <= pre_d;
      left_q <= left_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/aux_retry_decide.sv
module aux_retry_decide
  import aux_retry_pkg::*;
#(
  parameter int LEN_W           = 5,
  parameter int US_W            = 16,
  parameter int CNT_W           = 4,
  parameter int ACC_W           = 16,
  parameter int MAX_ATTEMPTS    = 7,
  parameter int ACK_RETRY_MAX   = 7,
  parameter int DEFER_RETRY_MAX = 7,
  parameter int I2C_DEFER_MAX   = 7,
  parameter int TIMEOUT_MAX     = 3,
  parameter int INVALID_MAX     = 2,
  parameter int ACK_WAIT_US     = 300,
  parameter int INVALID_WAIT_US = 400,
  parameter int POLL_US         = 1000,
  parameter int DEFER_TIME_US   = 50000
) (
  input  logic [2:0]                     res,
  input  logic [3:0]                     reply,
  input  logic [LEN_W-1:0]               bytes,
  input  logic                           cur_write,
  input  logic [LEN_W-1:0]               cur_len,
  input  logic [NUM_BUD-1:0][CNT_W-1:0]  bud_cnt,
  input  logic [CNT_W-1:0]               attempts,
  input  logic                           defer_seen,
  input  logic [ACC_W-1:0]               acc,
  input  logic [US_W-1:0]                defer_us,
  output act_e                           act,
  output logic [US_W-1:0]                wait_us,
  output logic [NUM_BUD-1:0]             bud_inc,
  output logic [NUM_BUD-1:0]             bud_clr,
  output logic                           to_status,
  output logic                           set_seen,
  output logic                           acc_ld,
  output logic [ACC_W-1:0]               acc_nxt
);
  logic [31:0] nxt [NUM_BUD];
  logic [31:0] sum_poll, sum_all;

  for (genvar g = 0; g < NUM_BUD; g++) begin : g_nxt
    assign nxt[g] = 32'(bud_cnt[g]) + 32'd1;
  end

  always_comb begin
    sum_poll = 32'(acc) + 32'(POLL_US);
    sum_all  = sum_poll + 32'(defer_us);
  end

  always_comb begin
    act       = ACT_RETRY;
    wait_us   = '0;
    bud_inc   = '0;
    bud_clr   = '0;
    to_status = 1'b0;
    set_seen  = 1'b0;
    acc_ld    = 1'b0;
    acc_nxt   = acc;
    case (res)
      RES_OK: begin
        bud_clr[BUD_TMO] = 1'b1;
        bud_clr[BUD_INV] = 1'b1;
        case (reply)
          RPL_ACK: begin
            if (!cur_write) begin
              if (bytes == cur_len) act = ACT_PASS;
              else begin
                bud_inc[BUD_ACK] = 1'b1;
                if (nxt[BUD_ACK] >= 32'(ACK_RETRY_MAX)) act = ACT_FAIL;
                else wait_us = US_W'(ACK_WAIT_US);
              end
            end else begin
              if (bytes == '0) act = ACT_PASS;
              else begin
                bud_inc[BUD_ACKW] = 1'b1;
                if (nxt[BUD_ACKW] >= 32'(ACK_RETRY_MAX)) act = ACT_FAIL;
                else begin
                  to_status = 1'b1;
                  wait_us   = US_W'(ACK_WAIT_US);
                end
              end
            end
          end
          RPL_DEFER: begin
            bud_inc[BUD_DEF] = 1'b1;
            set_seen         = 1'b1;
            if ((nxt[BUD_DEF] >= 32'(DEFER_RETRY_MAX)) &&
                (sum_poll >= 32'(DEFER_TIME_US)))
              act = ACT_FAIL;
            else begin
              wait_us = defer_us;
              acc_ld  = 1'b1;
              acc_nxt = (sum_all >= 32'(DEFER_TIME_US)) ? ACC_W'(DEFER_TIME_US)
                                                        : ACC_W'(sum_all);
            end
          end
          RPL_I2C_DEF: begin
            bud_clr[BUD_DEF] = 1'b1;
            bud_inc[BUD_I2C] = 1'b1;
            if (nxt[BUD_I2C] >= 32'(I2C_DEFER_MAX)) act = ACT_FAIL;
            else wait_us = defer_us;
          end
          default: act = ACT_FAIL;
        endcase
      end
      RES_INVALID: begin
        bud_inc[BUD_INV] = 1'b1;
        if (nxt[BUD_INV] >= 32'(INVALID_MAX)) act = ACT_FAIL;
        else wait_us = US_W'(INVALID_WAIT_US);
      end
      RES_TIMEOUT: begin
        if (defer_seen) begin
          bud_inc[BUD_DEF] = 1'b1;
          if (nxt[BUD_DEF] >= 32'(DEFER_RETRY_MAX)) act = ACT_FAIL;
          else wait_us = defer_us;
        end else begin
          bud_inc[BUD_TMO] = 1'b1;
          if (nxt[BUD_TMO] >= 32'(TIMEOUT_MAX)) act = ACT_FAIL;
        end
      end
      default: act = ACT_FAIL;
    endcase
    if ((act == ACT_RETRY) && (32'(attempts) >= 32'(MAX_ATTEMPTS))) act = ACT_FAIL;
  end
endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int CLK_PER_US      = 100,
  parameter int LEN_W           = 5,
  parameter int US_W            = 16,
  parameter int MAX_ATTEMPTS    = 7,
  parameter int ACK_RETRY_MAX   = 7,
  parameter int DEFER_RETRY_MAX = 7,
  parameter int I2C_DEFER_MAX   = 7,
  parameter int TIMEOUT_MAX     = 3,
  parameter int INVALID_MAX     = 2,
  parameter int ACK_WAIT_US     = 300,
  parameter int INVALID_WAIT_US = 400,
  parameter int POLL_US         = 1000,
  parameter int DEFER_TIME_US   = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  input  logic [US_W-1:0]  req_defer_us,
  output logic             att_start,
  output logic             att_write,
  output logic [LEN_W-1:0] att_len,
  input  logic             att_done,
  input  logic [2:0]       att_result,
  input  logic [3:0]       att_reply,
  input  logic [LEN_W-1:0] att_bytes,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [3:0]       last_reply
);
  localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1) + 1;
  localparam int ACC_W = $clog2(DEFER_TIME_US + 1) + 1;

  st_e                          st_q, st_d;
  logic                         wr_q, wr_d;
  logic [LEN_W-1:0]             len_q, len_d;
  logic [US_W-1:0]              dly_q;
  logic                         seen_q, seen_d;
  logic [ACC_W-1:0]             acc_q, acc_d;
  logic                         pass_q, pass_d;
  logic [3:0]                   rpl_q;
  logic                         take_req, judge;

  logic [NUM_BUD-1:0][CNT_W-1:0] bud_cnt;
  logic [NUM_BUD-1:0]            bud_inc, bud_clr;
  logic [CNT_W-1:0]              att_cnt;

  act_e                          act;
  logic [US_W-1:0]               wait_us;
  logic                          to_status, set_seen, acc_ld;
  logic [ACC_W-1:0]              acc_nxt;
  logic                          tmr_load, tmr_exp;

  assign take_req = (st_q == ST_IDLE) && req_valid;
  assign judge    = (st_q == ST_WAIT) && att_done;

  // per-kind retry budgets
  for (genvar g = 0; g < NUM_BUD; g++) begin : g_bud
    aux_retry_cnt #(.W(CNT_W)) u_bud (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (take_req || (judge && bud_clr[g])),
      .inc   (judge && bud_inc[g]),
      .cnt_o (bud_cnt[g])
    );
  end

  aux_retry_cnt #(.W(CNT_W)) u_att_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (take_req),
    .inc   (st_q == ST_ISSUE),
    .cnt_o (att_cnt)
  );

  aux_retry_decide #(
    .LEN_W(LEN_W), .US_W(US_W), .CNT_W(CNT_W), .ACC_W(ACC_W),
    .MAX_ATTEMPTS(MAX_ATTEMPTS), .ACK_RETRY_MAX(ACK_RETRY_MAX),
    .DEFER_RETRY_MAX(DEFER_RETRY_MAX), .I2C_DEFER_MAX(I2C_DEFER_MAX),
    .TIMEOUT_MAX(TIMEOUT_MAX), .INVALID_MAX(INVALID_MAX),
    .ACK_WAIT_US(ACK_WAIT_US), .INVALID_WAIT_US(INVALID_WAIT_US),
    .POLL_US(POLL_US), .DEFER_TIME_US(DEFER_TIME_US)
  ) u_decide (
    .res        (att_result),
    .reply      (att_reply),
    .bytes      (att_bytes),
    .cur_write  (wr_q),
    .cur_len    (len_q),
    .bud_cnt    (bud_cnt),
    .attempts   (att_cnt),
    .defer_seen (seen_q),
    .acc        (acc_q),
    .defer_us   (dly_q),
    .act        (act),
    .wait_us    (wait_us),
    .bud_inc    (bud_inc),
    .bud_clr    (bud_clr),
    .to_status  (to_status),
    .set_seen   (set_seen),
    .acc_ld     (acc_ld),
    .acc_nxt    (acc_nxt)
  );

  aux_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_us (wait_us),
    .expire  (tmr_exp)
  );

  always_comb begin
    st_d     = st_q;
    wr_d     = wr_q;
    len_d    = len_q;
    seen_d   = seen_q;
    acc_d    = acc_q;
    pass_d   = pass_q;
    tmr_load = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d   = ST_ISSUE;
        wr_d   = req_write;
        len_d  = req_len;
        seen_d = 1'b0;
        acc_d  = '0;
        pass_d = 1'b0;
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: if (att_done) begin
        if (set_seen) seen_d = 1'b1;
        if (acc_ld)   acc_d  = acc_nxt;
        if (act == ACT_RETRY) begin
          if (to_status) begin
            wr_d  = 1'b0;
            len_d = '0;
          end
          if (wait_us == '0) st_d = ST_ISSUE;
          else begin
            st_d     = ST_DELAY;
            tmr_load = 1'b1;
          end
        end else begin
          st_d   = ST_FIN;
          pass_d = (act == ACT_PASS);
        end
      end
      ST_DELAY: if (tmr_exp) st_d = ST_ISSUE;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wr_q   <= 1'b0;
      len_q  <= '0;
      dly_q  <= '0;
      seen_q <= 1'b0;
      acc_q  <= '0;
      pass_q <= 1'b0;
      rpl_q  <= '0;
    end else begin
      st_q   <= st_d;
      wr_q   <= wr_d;
      len_q  <= len_d;
      seen_q <= seen_d;
      acc_q  <= acc_d;
      pass_q <= pass_d;
      if (take_req) dly_q <= req_defer_us;
      if (judge)    rpl_q <= att_reply;
    end
  end

  assign att_start  = (st_q == ST_ISSUE);
  assign att_write  = wr_q;
  assign att_len    = len_q;
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_FIN);
  assign pass       = pass_q;
  assign last_reply = rpl_q;
endmodule

// File: rtl/aux_retry_ctrl_chk.sv
module aux_retry_ctrl_chk #(
  parameter int LEN_W        = 5,
  parameter int MAX_ATTEMPTS = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             att_start,
  input logic             att_write,
  input logic [LEN_W-1:0] att_len,
  input logic             att_done,
  input logic [2:0]       att_result,
  input logic [3:0]       att_reply,
  input logic [LEN_W-1:0] att_bytes,
  input logic             busy,
  input logic             done,
  input logic             pass
);
  int unsigned n_att;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         n_att <= 0;
    else if (done)      n_att <= 0;
    else if (att_start) n_att <= n_att + 1;
  end

  // R1
  start_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> att_start);

  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    att_start |=> !att_start);

  // R2
  attempt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    att_start |-> (n_att < MAX_ATTEMPTS));

  // R3
  read_full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (att_done && busy && !done && (att_result == 3'd0) && (att_reply == 4'h0) &&
     !att_write && (att_bytes == att_len)) |=> (done && pass));

  // R12
  discon_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (att_done && busy && !done && (att_result == 3'd3)) |=> (done && !pass));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind aux_retry_ctrl aux_retry_ctrl_chk #(.LEN_W(LEN_W), .MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .att_start  (att_start),
  .att_write  (att_write),
  .att_len    (att_len),
  .att_done   (att_done),
  .att_result (att_result),
  .att_reply  (att_reply),
  .att_bytes  (att_bytes),
  .busy       (busy),
  .done       (done),
  .pass       (pass)
);

// File: tb/aux_retry_ctrl_tb.sv
module aux_retry_ctrl_tb;
  localparam int CPU   = 1;
  localparam int LW    = 5;
  localparam int UW    = 16;
  localparam int DMAX  = 3;
  localparam int DTIME = 100;
  localparam int POLL  = 10;

  // outcome kinds
  localparam int K_FULL = 0, K_SHORT = 1, K_DEF = 2, K_I2CD = 3, K_TMO = 4,
                 K_INV = 5, K_NACK = 6, K_I2CN = 7, K_DISC = 8, K_BUSY = 9, K_UNK = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [LW-1:0] req_len;
  logic [UW-1:0] req_defer_us;
  logic att_start, att_write, att_done, busy, done, pass;
  logic [LW-1:0] att_len, att_bytes;
  logic [2:0] att_result;
  logic [3:0] att_reply, last_reply;

  always #2.5 clk = ~clk;

  aux_retry_ctrl #(
    .CLK_PER_US(CPU), .LEN_W(LW), .US_W(UW), .DEFER_RETRY_MAX(DMAX),
    .POLL_US(POLL), .DEFER_TIME_US(DTIME)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_len(req_len), .req_defer_us(req_defer_us), .att_start(att_start),
    .att_write(att_write), .att_len(att_len), .att_done(att_done),
    .att_result(att_result), .att_reply(att_reply), .att_bytes(att_bytes),
    .busy(busy), .done(done), .pass(pass), .last_reply(last_reply)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int seq [16];

  // requirement-level model state
  int m_ack, m_ackw, m_def, m_i2c, m_tmo, m_inv, m_acc, m_att, m_len, m_dly;
  bit m_seen, m_write;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic outcome(input int k, output int res, output int rep, output int byt);
    res = 0; rep = 0; byt = 0;
    case (k)
      K_FULL:  byt = m_write ? 0 : m_len;
      K_SHORT: byt = m_write ? 1 : ((m_len == 0) ? 1 : m_len - 1);
      K_DEF:   rep = 2;
      K_I2CD:  rep = 8;
      K_TMO:   res = 2;
      K_INV:   res = 1;
      K_NACK:  rep = 1;
      K_I2CN:  rep = 4;
      K_DISC:  res = 3;
      K_BUSY:  res = 4;
      default: rep = 3;
    endcase
  endtask

  // act: 0 retry, 1 pass, 2 fail
  task automatic model_step(input int res, input int rep, input int byt,
                            output int act, output int w);
    act = 0; w = 0;
    if (res == 0) begin
      m_tmo = 0; m_inv = 0;                      // R10
      if (rep == 0) begin
        if (!m_write) begin
          if (byt == m_len) act = 1;
          else begin m_ack++; if (m_ack >= 7) act = 2; else w = 300; end
        end else begin
          if (byt == 0) act = 1;
          else begin
            m_ackw++;
            if (m_ackw >= 7) act = 2;
            else begin w = 300; m_write = 0; m_len = 0; end
          end
        end
      end else if (rep == 2) begin
        m_def++; m_seen = 1;
        if (m_def >= DMAX && m_acc + POLL >= DTIME) act = 2;
        else begin w = m_dly; m_acc += POLL + m_dly; end
      end else if (rep == 8) begin
        m_def = 0; m_i2c++;
        if (m_i2c >= 7) act = 2; else w = m_dly;
      end else act = 2;
    end else if (res == 1) begin
      m_inv++; if (m_inv >= 2) act = 2; else w = 400;
    end else if (res == 2) begin
      if (m_seen) begin m_def++; if (m_def >= DMAX) act = 2; else w = m_dly; end
      else begin m_tmo++; if (m_tmo >= 3) act = 2; end
    end else act = 2;
    if (act == 0 && m_att >= 7) act = 2;
  endtask

  task automatic run_txn(input string tag, input bit wr, input int len, input int dly,
                         input int exp_att);
    int gap_exp = 1;
    int t_ref;
    m_ack = 0; m_ackw = 0; m_def = 0; m_i2c = 0; m_tmo = 0; m_inv = 0;
    m_acc = 0; m_att = 0; m_seen = 0; m_write = wr; m_len = len; m_dly = dly;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_len = LW'(len); req_defer_us = UW'(dly);
    t_ref = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "busy after request", int'(busy), 1);
    for (int i = 0; i < 16; i++) begin
      int res, rep, byt, act, w;
      while (att_start !== 1'b1) @(negedge clk);
      chk(tag, "start gap (R13)", cyc - t_ref, gap_exp);
      chk(tag, "att_write", int'(att_write), int'(m_write));
      chk(tag, "att_len", int'(att_len), m_len);
      m_att++;
      outcome(seq[i], res, rep, byt);
      @(negedge clk);
      att_done = 1'b1; att_result = 3'(res); att_reply = 4'(rep); att_bytes = LW'(byt);
      t_ref = cyc;
      @(negedge clk);
      att_done = 1'b0;
      model_step(res, rep, byt, act, w);
      if (act != 0) begin
        chk(tag, "done pulse", int'(done), 1);
        chk(tag, "pass flag", int'(pass), (act == 1) ? 1 : 0);
        chk(tag, "last_reply", int'(last_reply), rep);
        if (exp_att > 0) chk(tag, "attempt count", m_att, exp_att);
        break;
      end
      chk(tag, "no done on retry", int'(done), 0);
      gap_exp = w * CPU + 1;
    end
    @(negedge clk);
    chk(tag, "idle after done", int'(busy), 0);
  endtask

  task automatic fill(input int k);
    for (int i = 0; i < 16; i++) seq[i] = k;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_len = '0; req_defer_us = '0;
    att_done = 1'b0; att_result = '0; att_reply = '0; att_bytes = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset start", int'(att_start), 0);
    chk("R3", "reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(K_FULL);  run_txn("R3", 1'b0, 4, 0, 1);
    fill(K_FULL);  run_txn("R3", 1'b1, 3, 0, 1);
    fill(K_SHORT); run_txn("R4", 1'b0, 4, 0, 7);
    fill(K_FULL);  seq[0] = K_SHORT; run_txn("R5", 1'b1, 3, 0, 2);
    fill(K_SHORT); run_txn("R5", 1'b1, 6, 0, 7);
    fill(K_INV);   run_txn("R8", 1'b0, 2, 0, 2);
    fill(K_TMO);   run_txn("R9", 1'b0, 2, 0, 3);
    fill(K_FULL);  seq[0] = K_TMO; seq[1] = K_TMO; seq[2] = K_SHORT;
                   seq[3] = K_TMO; seq[4] = K_TMO; run_txn("R10", 1'b0, 2, 0, 6);
    fill(K_DEF);   run_txn("R6", 1'b0, 1, 20, 4);
    fill(K_DEF);   run_txn("R2", 1'b0, 1, 0, 7);
    fill(K_TMO);   seq[0] = K_DEF; run_txn("R11", 1'b0, 1, 5, 3);
    fill(K_FULL);  seq[0] = K_DEF; seq[1] = K_DEF; seq[2] = K_I2CD;
                   seq[3] = K_DEF; seq[4] = K_DEF; run_txn("R7", 1'b0, 1, 40, 6);
    fill(K_I2CD);  run_txn("R7", 1'b0, 1, 3, 7);
    fill(K_NACK);  run_txn("R12", 1'b1, 2, 0, 1);
    fill(K_I2CN);  run_txn("R12", 1'b0, 2, 0, 1);
    fill(K_DISC);  run_txn("R12", 1'b0, 2, 0, 1);
    fill(K_BUSY);  run_txn("R12", 1'b0, 2, 0, 1);
    fill(K_UNK);   run_txn("R12", 1'b0, 2, 0, 1);

    void'($urandom(32'd2024));
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 16; i++) begin
        int r = int'($urandom % 20);
        seq[i] = (r < 5) ? K_FULL : (r < 9) ? K_SHORT : (r < 12) ? K_DEF :
                 (r < 14) ? K_TMO : (r < 16) ? K_I2CD : (r < 18) ? K_INV :
                 (r < 19) ? K_NACK : K_DISC;
      end
      run_txn("R13", 1'($urandom % 2), int'($urandom % 9), int'($urandom % 30), 0);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule